// File: doc/BRIEF.md
# Prefixed Bit Test / Set / Reset Unit

This unit executes the bit-manipulation group of an 8-bit processor. It is reached through a one-byte escape prefix, optionally preceded by an index-select prefix. It pulls instruction bytes from a fetch port and decodes the operation, the bit number and the operand. It then reads the operand from one of three places: a register-file port, memory addressed by the 16-bit pointer register, or memory addressed by an index register plus a signed displacement. It tests, sets or clears the selected bit, and writes the result back to the register, to memory or to the flag register.

Each clock stands for one T-state. Byte fetches, the memory read, the write-back and the end of the instruction all fall on fixed T-states, so every addressing form has a known length. A single-cycle completion strobe follows the last T-state. A byte sequence outside the supported group raises a single-cycle error strobe, makes no writes and returns the unit to idle.

Top module: `bitop_unit`

## Requirements
- R1: An instruction starts with escape byte 0xCB, or with an index prefix 0xDD (pointer `ixPtr`) or 0xFD (pointer `iyPtr`) followed by 0xCB. In the operation byte, bits [7:6] select the operation (01 test, 10 clear, 11 set), bits [5:3] the bit number and bits [2:0] the operand (110 = memory, any other value = that register-file entry).
- R2: A test writes the flags once. Z (bit 6) becomes the inverse of the tested bit, H (bit 4) becomes 1 and N (bit 1) becomes 0. All other flag bits (S bit 7, bit 5, bit 3, P/V bit 2, C bit 0) keep their value. The operand is not written.
- R3: Set and clear change only the selected bit of the operand and write it back to where it was read from. They do not write the flags.
- R4: A register-form instruction lasts 8 T-states. Completion shows 8 cycles after the escape byte is taken, and no memory access takes place.
- R5: A pointer-form set or clear lasts 15 T-states. It reads at T-state 10 and writes at T-state 14, both at `hlPtr`. A pointer-form test lasts 12 T-states and only reads.
- R6: An indexed instruction addresses memory at the chosen index register plus the sign-extended displacement, modulo 2^16. Set and clear last 23 T-states (read at T-state 18, write at T-state 22). A test lasts 20 T-states and only reads.
- R7: `done` is high for exactly one cycle, directly after the last T-state.
- R8: These byte sequences raise `illegal` for one cycle, in the cycle after the offending byte is taken, with no writes and no `done`: a first byte that is not a valid prefix, an operation field of 00, a non-0xCB byte after an index prefix, or an indexed operand field other than 110.
- R9: Bytes are taken only when `fetchTake` and `fetchValid` are both high. In idle, `fetchTake` is high. After that, bytes are taken only at T-states 0 and 4 (escape-only forms) or at T-states 0, 4, 8 and 11 (indexed forms).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A byte is offered on `fetchByte` |
| fetchByte | input | 8 | Instruction byte |
| fetchTake | output | 1 | Unit consumes the offered byte this cycle |
| memAddr | output | 16 | Memory address |
| memRd | output | 1 | Memory read strobe; data sampled this cycle |
| memWr | output | 1 | Memory write strobe |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid for `memAddr` in the same cycle |
| hlPtr | input | 16 | Pointer register for the indirect form |
| ixPtr | input | 16 | First index register |
| iyPtr | input | 16 | Second index register |
| rfAddr | output | 3 | Register-file entry selected |
| rfRdata | input | 8 | Register-file read data for `rfAddr` |
| rfWe | output | 1 | Register-file write strobe |
| rfWdata | output | 8 | Register-file write data |
| flagsIn | input | 8 | Current flag register |
| flagsWe | output | 1 | Flag register write strobe |
| flagsOut | output | 8 | New flag value |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Unsupported-sequence pulse |

## Verification
The assertions assume that once an instruction has begun, every byte it asks for is already on offer, because the unit has no wait states. They also assume that the pointer and index inputs stay constant for the whole instruction. The bench stages the full byte sequence before the first byte is taken and advances it only on taken cycles. It changes the register values only between instructions. The register file and memory are modelled as combinational reads that the bench updates on the write strobes.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam logic [7:0] ESC_BYTE = 8'hCB;
  localparam int FLAG_Z = 6;
  localparam int FLAG_H = 4;
  localparam int FLAG_N = 1;
  localparam logic [2:0] MEM_SEL = 3'b110;

  typedef struct packed {
    logic latchOp;
    logic latchDisp;
    logic readMem;
    logic writeMem;
    logic writeReg;
    logic writeFlags;
    logic useIdx;
    logic idxSel;
  } ctlT;
endpackage

// File: rtl/bitop_ctl.sv
module bitop_ctl
  import bitop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchValid,
  input  logic [7:0] fetchByte,
  output logic       fetchTake,
  output ctlT        ctl,
  output logic       done,
  output logic       illegal
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} stateT;

  localparam int TW = 5;

  stateT         state;
  logic [TW-1:0] tCnt;
  logic          isIdx, idxSelQ, decoded, isMem, isTest, illegalQ;
  logic [TW-1:0] lastT, readT;
  logic          opTake, cbTake, dispTake, opBad, atLast, isPrefix;

  always_comb begin
    if (isIdx)      lastT = isTest ? TW'(19) : TW'(22);
    else if (isMem) lastT = isTest ? TW'(11) : TW'(14);
    else            lastT = TW'(7);
    readT    = isIdx ? TW'(18) : TW'(10);
    isPrefix = (fetchByte[7:6] == 2'b11) && (fetchByte[4:0] == 5'b11101);
    opTake   = (state == ST_RUN) && ((!isIdx && tCnt == TW'(4)) || (isIdx && tCnt == TW'(11)));
    cbTake   = (state == ST_RUN) && isIdx && (tCnt == TW'(4));
    dispTake = (state == ST_RUN) && isIdx && (tCnt == TW'(8));
    opBad    = (fetchByte[7:6] == 2'b00) || (isIdx && fetchByte[2:0] != MEM_SEL);
    atLast   = (state == ST_RUN) && decoded && (tCnt == lastT);
    fetchTake = (state == ST_IDLE) || opTake || cbTake || dispTake;

    ctl.latchOp    = opTake && fetchValid;
    ctl.latchDisp  = dispTake && fetchValid;
    ctl.readMem    = (state == ST_RUN) && decoded && isMem && (tCnt == readT);
    ctl.writeMem   = atLast && isMem && !isTest;
    ctl.writeReg   = atLast && !isMem && !isTest;
    ctl.writeFlags = atLast && isTest;
    ctl.useIdx     = isIdx;
    ctl.idxSel     = idxSelQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tCnt     <= '0;
      isIdx    <= 1'b0;
      idxSelQ  <= 1'b0;
      decoded  <= 1'b0;
      isMem    <= 1'b0;
      isTest   <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      illegalQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fetchValid) begin
            tCnt    <= TW'(1);
            decoded <= 1'b0;
            if (fetchByte == ESC_BYTE) begin
              state <= ST_RUN;
              isIdx <= 1'b0;
            end else if (isPrefix) begin
              state   <= ST_RUN;
              isIdx   <= 1'b1;
              idxSelQ <= fetchByte[5];
            end else begin
              illegalQ <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          tCnt <= tCnt + TW'(1);
          if (opTake && fetchValid) begin
            if (opBad) begin
              illegalQ <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              decoded <= 1'b1;
              isMem   <= isIdx || (fetchByte[2:0] == MEM_SEL);
              isTest  <= (fetchByte[7:6] == 2'b01);
            end
          end
          if (cbTake && fetchValid && fetchByte != ESC_BYTE) begin
            illegalQ <= 1'b1;
            state    <= ST_IDLE;
          end
          if (atLast) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done    = (state == ST_DONE);
  assign illegal = illegalQ;

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(illegal) |-> !done && $past(fetchTake && fetchValid));
  // R5
  write_last_chk: assert property (@(posedge clk) disable iff (!rstN) ctl.writeMem |=> done);
  // R1
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(ctl.readMem && ctl.writeMem));
  // R9
  fetch_fed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchTake && state == ST_RUN) |-> fetchValid);
endmodule

// File: rtl/bitop_dp.sv
module bitop_dp
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic [7:0]        fetchByte,
  input  logic [ADDR_W-1:0] hlPtr,
  input  logic [ADDR_W-1:0] ixPtr,
  input  logic [ADDR_W-1:0] iyPtr,
  input  logic [7:0]        memRdata,
  input  logic [7:0]        rfRdata,
  input  logic [7:0]        flagsIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [7:0]        memWdata,
  output logic [2:0]        rfAddr,
  output logic              rfWe,
  output logic [7:0]        rfWdata,
  output logic              flagsWe,
  output logic [7:0]        flagsOut
);
  logic [7:0]        opQ, dispQ, memByte;
  logic [2:0]        bitSel;
  logic [7:0]        mask, operand, modified;
  logic              tested;
  logic [ADDR_W-1:0] dispExt, idxBase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ     <= '0;
      dispQ   <= '0;
      memByte <= '0;
    end else begin
      if (ctl.latchOp)   opQ     <= fetchByte;
      if (ctl.latchDisp) dispQ   <= fetchByte;
      if (ctl.readMem)   memByte <= memRdata;
    end
  end

  always_comb begin
    bitSel   = opQ[5:3];
    mask     = 8'b1 << bitSel;
    operand  = (opQ[2:0] == MEM_SEL) ? memByte : rfRdata;
    modified = opQ[6] ? (operand | mask) : (operand & ~mask);
    tested   = operand[bitSel];
    dispExt  = {{(ADDR_W-8){dispQ[7]}}, dispQ};
    idxBase  = ctl.idxSel ? iyPtr : ixPtr;
    memAddr  = ctl.useIdx ? idxBase + dispExt : hlPtr;
    flagsOut = flagsIn;
    flagsOut[FLAG_Z] = ~tested;
    flagsOut[FLAG_H] = 1'b1;
    flagsOut[FLAG_N] = 1'b0;
  end

  assign memRd    = ctl.readMem;
  assign memWr    = ctl.writeMem;
  assign memWdata = modified;
  assign rfAddr   = opQ[2:0];
  assign rfWe     = ctl.writeReg;
  assign rfWdata  = modified;
  assign flagsWe  = ctl.writeFlags;

  // R3
  one_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $countones(memWdata ^ memByte) <= 1);
  // R5
  same_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(memRd, 4) && memAddr == $past(memAddr, 4));
  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagsWe |-> !rfWe && !memWr);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [7:0]        fetchByte,
  output logic              fetchTake,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  input  logic [ADDR_W-1:0] hlPtr,
  input  logic [ADDR_W-1:0] ixPtr,
  input  logic [ADDR_W-1:0] iyPtr,
  output logic [2:0]        rfAddr,
  input  logic [7:0]        rfRdata,
  output logic              rfWe,
  output logic [7:0]        rfWdata,
  input  logic [7:0]        flagsIn,
  output logic              flagsWe,
  output logic [7:0]        flagsOut,
  output logic              done,
  output logic              illegal
);
  ctlT ctl;

  bitop_ctl uCtl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchByte(fetchByte),
    .fetchTake(fetchTake), .ctl(ctl), .done(done), .illegal(illegal)
  );

  bitop_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fetchByte(fetchByte),
    .hlPtr(hlPtr), .ixPtr(ixPtr), .iyPtr(iyPtr), .memRdata(memRdata),
    .rfRdata(rfRdata), .flagsIn(flagsIn), .memAddr(memAddr), .memRd(memRd),
    .memWr(memWr), .memWdata(memWdata), .rfAddr(rfAddr), .rfWe(rfWe),
    .rfWdata(rfWdata), .flagsWe(flagsWe), .flagsOut(flagsOut)
  );
endmodule

// File: tb/sim_bitop_unit.sv
`timescale 1ns/1ps
module sim_bitop_unit;
  logic clk = 1'b0, rstN = 1'b0;
  logic fetchValid = 1'b0;
  logic [7:0] fetchByte = 8'h00;
  logic fetchTake, memRd, memWr, rfWe, flagsWe, done, illegal;
  logic [15:0] memAddr, hlPtr = 16'h3400, ixPtr = 16'h12F0, iyPtr = 16'h7C10;
  logic [7:0] memWdata, memRdata, rfRdata, rfWdata, flagsOut;
  logic [2:0] rfAddr;
  logic [7:0] mem [256];
  logic [7:0] regs [8];
  logic [7:0] flagsReg = 8'h00;
  logic [7:0] prog [4];

  int nChecks = 0, nErr = 0;
  int tDone, tIll, takeMask, nRd, nWr, nRf, nFl;
  logic [15:0] rdAddr, wrAddr;

  assign memRdata = mem[memAddr[7:0]];
  assign rfRdata  = regs[rfAddr];

  always #4 clk = ~clk;

  bitop_unit u0 (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchByte(fetchByte),
    .fetchTake(fetchTake), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .memRdata(memRdata), .hlPtr(hlPtr), .ixPtr(ixPtr),
    .iyPtr(iyPtr), .rfAddr(rfAddr), .rfRdata(rfRdata), .rfWe(rfWe),
    .rfWdata(rfWdata), .flagsIn(flagsReg), .flagsWe(flagsWe),
    .flagsOut(flagsOut), .done(done), .illegal(illegal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runInstr(input logic [7:0] p0, p1, p2, p3, input int n);
    int ptr = 0;
    prog[0] = p0; prog[1] = p1; prog[2] = p2; prog[3] = p3;
    tDone = -1; tIll = -1; takeMask = 0; nRd = 0; nWr = 0; nRf = 0; nFl = 0;
    rdAddr = '0; wrAddr = '0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      fetchValid = (ptr < n);
      fetchByte  = prog[ptr < 4 ? ptr : 3];
      #1;
      if (fetchTake && fetchValid) begin takeMask |= (1 << t); ptr++; end
      if (memRd) begin rdAddr = memAddr; nRd++; end
      if (memWr) begin wrAddr = memAddr; mem[memAddr[7:0]] = memWdata; nWr++; end
      if (rfWe) begin regs[rfAddr] = rfWdata; nRf++; end
      if (flagsWe) begin flagsReg = flagsOut; nFl++; end
      if (done) tDone = t;
      if (illegal) tIll = t;
      if (done || illegal) break;
    end
    fetchValid = 1'b0;
  endtask

  function automatic logic [7:0] testFlags(input logic [7:0] f, input logic bitv);
    return {f[7], ~bitv, f[5], 1'b1, f[3], f[2], 1'b0, f[0]};
  endfunction

  initial begin
    #(200000 * 8);
    nErr++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] val, expV, fl, expF, opc, d;
    logic [15:0] ea;
    logic [7:0] dList [5];
    dList[0] = 8'h00; dList[1] = 8'h7F; dList[2] = 8'h80; dList[3] = 8'hFF; dList[4] = 8'h05;
    for (int k = 0; k < 256; k++) mem[k] = 8'(k * 13 + 7);
    for (int k = 0; k < 8; k++) regs[k] = 8'(k * 37);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R7 R9 reset state
    check(!done && !illegal, "R7 reset strobes", {30'd0, done, illegal}, 0);
    check(!memRd && !memWr && !rfWe && !flagsWe, "R3 reset writes",
          {28'd0, memRd, memWr, rfWe, flagsWe}, 0);
    check(fetchTake, "R9 idle take", fetchTake, 1);
    repeat (5) @(negedge clk);
    check(!done && !illegal, "R9 idle without bytes", {30'd0, done, illegal}, 0);

    // Register form sweep: R1 R2 R3 R4 R9
    for (int op = 1; op < 4; op++)
      for (int b = 0; b < 8; b++)
        for (int r = 0; r < 8; r++) begin
          if (r == 6) continue;
          for (int k = 0; k < 8; k++) regs[k] = 8'(k * 37 + b * 11 + op * 5);
          flagsReg = 8'(8'h96 ^ (b * 8'h21) ^ r);
          val = regs[r]; fl = flagsReg;
          opc = {2'(op), 3'(b), 3'(r)};
          runInstr(8'hCB, opc, 8'h00, 8'h00, 2);
          check(tDone == 8, "R4 reg length", tDone, 8);
          check(takeMask == 32'h11, "R9 reg takes", takeMask, 32'h11);
          check(nRd == 0 && nWr == 0, "R4 no memory", nRd + nWr, 0);
          if (op == 1) begin
            expF = testFlags(fl, val[b]);
            check(flagsReg == expF, "R2 reg test flags", flagsReg, expF);
            check(regs[r] == val && nRf == 0, "R2 reg operand kept", regs[r], val);
          end else begin
            expV = (op == 3) ? (val | (8'h1 << b)) : (val & ~(8'h1 << b));
            check(regs[r] == expV, "R3 reg result", regs[r], expV);
            check(flagsReg == fl && nFl == 0, "R3 reg flags kept", flagsReg, fl);
          end
        end

    // Pointer form: R5 R2 R3
    for (int op = 1; op < 4; op++)
      for (int b = 0; b < 8; b++) begin
        hlPtr = 16'h3400 + 16'(b * 29 + op);
        mem[hlPtr[7:0]] = 8'(b * 53 + op * 17);
        flagsReg = 8'(8'h5A ^ (b * 8'h11));
        val = mem[hlPtr[7:0]]; fl = flagsReg;
        runInstr(8'hCB, {2'(op), 3'(b), 3'b110}, 8'h00, 8'h00, 2);
        check(rdAddr == hlPtr && nRd == 1, "R5 read addr", rdAddr, hlPtr);
        if (op == 1) begin
          check(tDone == 12, "R5 test length", tDone, 12);
          check(nWr == 0, "R5 test no write", nWr, 0);
          expF = testFlags(fl, val[b]);
          check(flagsReg == expF, "R2 mem test flags", flagsReg, expF);
        end else begin
          check(tDone == 15, "R5 rmw length", tDone, 15);
          check(nWr == 1 && wrAddr == hlPtr, "R5 write addr", wrAddr, hlPtr);
          expV = (op == 3) ? (val | (8'h1 << b)) : (val & ~(8'h1 << b));
          check(mem[hlPtr[7:0]] == expV, "R3 mem result", mem[hlPtr[7:0]], expV);
          check(flagsReg == fl, "R3 mem flags kept", flagsReg, fl);
        end
      end

    // Indexed form: R6 R9 R2 R3
    for (int sel = 0; sel < 2; sel++)
      for (int op = 1; op < 4; op++)
        for (int b = 0; b < 8; b++)
          for (int di = 0; di < 5; di++) begin
            d  = dList[di];
            ea = (sel ? iyPtr : ixPtr) + {{8{d[7]}}, d};
            mem[ea[7:0]] = 8'(b * 71 + di * 9 + op);
            flagsReg = 8'(8'hC3 ^ (di * 8'h0F) ^ b);
            val = mem[ea[7:0]]; fl = flagsReg;
            runInstr(sel ? 8'hFD : 8'hDD, 8'hCB, d, {2'(op), 3'(b), 3'b110}, 4);
            check(takeMask == 32'h911, "R9 idx takes", takeMask, 32'h911);
            check(rdAddr == ea, "R6 idx addr", rdAddr, ea);
            if (op == 1) begin
              check(tDone == 20 && nWr == 0, "R6 idx test length", tDone, 20);
              expF = testFlags(fl, val[b]);
              check(flagsReg == expF, "R2 idx test flags", flagsReg, expF);
            end else begin
              check(tDone == 23, "R6 idx rmw length", tDone, 23);
              check(wrAddr == ea && nWr == 1, "R6 idx write addr", wrAddr, ea);
              expV = (op == 3) ? (val | (8'h1 << b)) : (val & ~(8'h1 << b));
              check(mem[ea[7:0]] == expV, "R3 idx result", mem[ea[7:0]], expV);
            end
          end

    // Illegal sequences: R8
    fl = flagsReg;
    runInstr(8'h00, 8'h00, 8'h00, 8'h00, 1);
    check(tIll == 1 && tDone == -1, "R8 bad prefix", tIll, 1);
    runInstr(8'hCB, 8'h05, 8'h00, 8'h00, 2);
    check(tIll == 5 && tDone == -1, "R8 op field 00", tIll, 5);
    check(nRf == 0 && nFl == 0 && nWr == 0, "R8 no writes", nRf + nFl + nWr, 0);
    runInstr(8'hDD, 8'h00, 8'h00, 8'h00, 2);
    check(tIll == 5 && tDone == -1, "R8 idx without escape", tIll, 5);
    runInstr(8'hFD, 8'hCB, 8'h10, 8'hC7, 4);
    check(tIll == 12 && tDone == -1, "R8 idx operand field", tIll, 12);
    check(nWr == 0 && nRd == 0 && flagsReg == fl, "R8 idx no access", nWr + nRd, 0);
    @(negedge clk); #1;
    check(!illegal && !done, "R7 strobes single cycle", {30'd0, illegal, done}, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule